// File: doc/BRIEF.md
# DMA Channel Enable Command Registers

This block is the register slice of a 32-channel DMA engine that holds two per-channel vectors: the hardware request enable vector, which tells the engine which channels may accept requests, and the error interrupt enable vector, which picks the channels whose error flags may raise the shared error interrupt. Software does not write the request enable vector directly. It writes an 8-bit set command to a write-only address. The command names one channel to enable, or uses a global flag to enable every channel, or carries a no-op flag that makes the whole command do nothing.

Each byte lane of a 32-bit bus write to the command address is a separate command. A driver can therefore pack up to four channel enables into one word, and can fill the lanes it does not need with no-op bytes. Per-channel error inputs are registered once. The interrupt output is the OR of every registered error flag that has its enable bit set.

Top module: `dma_chan_en_regs`

## Requirements
- R1: A set command with bit 7 = 0 and bit 6 = 0 sets request enable bit `cmd[4:0]` on the clock edge of the write. Every other bit keeps its value.
- R2: The request enable vector resets to all zeroes. No bus write ever clears a bit of it.
- R3: A set command with bit 7 = 0 and bit 6 = 1 sets all 32 request enable bits, whatever bits 5:0 hold.
- R4: A set command with bit 7 = 1 (no-op) leaves the request enable vector unchanged, whatever the other bits hold.
- R5: The set command address is byte offset 0x14. A read at 0x14 returns 0x00000000.
- R6: When bit 6 of a command is 0, bit 5 has no effect. The channel number is `cmd[4:0]` only.
- R7: In a write to 0x14, byte lane k (bits 8k+7:8k) is decoded as its own command when `bus_be_i[k]` = 1. All such lanes take effect in the same cycle and their results are OR-ed together. Lanes whose strobe is 0 have no effect.
- R8: The error interrupt enable register is read/write at byte offset 0x18 and resets to zero. A write updates only the byte lanes whose strobes are set.
- R9: `err_irq_o` is 1 when some channel n has `err_i[n]` registered high on the previous edge and error interrupt enable bit n is 1. It follows a change of either input one clock later.
- R10: The request enable vector reads back at byte offset 0x0C, and writes there are ignored. Reads at any unmapped address return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_addr_i | input | 8 | Byte address within the block |
| bus_we_i | input | 1 | Write strobe |
| bus_be_i | input | 4 | Byte lane strobes |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data for bus_addr_i, combinational |
| err_i | input | 32 | Per-channel error signals |
| req_en_o | output | 32 | Request enable vector |
| err_irq_o | output | 1 | Combined error interrupt |

## Verification
The bench builds the block with its defaults: 32 channels and a 32-bit bus of four byte lanes. With these values, channel 31 and the top byte lane can be reached in one multi-lane write, alongside lanes whose strobes are off. A full-width global set is reachable, and byte-masked enable writes cover the whole interrupt vector. A behavioural model runs in step with the design and is compared with the enable vector and the interrupt output on every cycle. Directed writes cover the no-op, global, reserved-bit and strobe-off cases.

// File: rtl/dma_chan_en_pkg.sv
package dma_chan_en_pkg;
  localparam int unsigned CMD_W   = 8;
  localparam logic [7:0]  A_REQEN = 8'h0C;
  localparam logic [7:0]  A_SETRQ = 8'h14;
  localparam logic [7:0]  A_ERRIE = 8'h18;

  typedef struct packed {
    logic       nop;
    logic       glb;
    logic       rsv;
    logic [4:0] ch;
  } set_cmd_t;
endpackage

// File: rtl/set_cmd_lane.sv
module set_cmd_lane
  import dma_chan_en_pkg::*;
#(
  parameter int unsigned NUM_CH = 32
) (
  input  logic              vld_i,
  input  logic [CMD_W-1:0]  cmd_i,
  output logic [NUM_CH-1:0] mask_o
);
  localparam int unsigned CH_W = $clog2(NUM_CH);

  set_cmd_t cmd;
  logic     unused_rsv;

  assign cmd        = set_cmd_t'(cmd_i);
  assign unused_rsv = cmd.rsv;

  always_comb begin
    mask_o = '0;
    if (vld_i && !cmd.nop) begin
      if (cmd.glb) mask_o = '1;
      else         mask_o[cmd.ch[CH_W-1:0]] = 1'b1;
    end
  end
endmodule

// File: rtl/req_en_reg.sv
module req_en_reg #(
  parameter int unsigned NUM_CH = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NUM_CH-1:0] set_i,
  output logic [NUM_CH-1:0] en_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) en_o <= '0;
    else         en_o <= en_o | set_i;
  end
endmodule

// File: rtl/err_irq_unit.sv
module err_irq_unit #(
  parameter int unsigned NUM_CH = 32,
  parameter int unsigned LANES  = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ie_we_i,
  input  logic [LANES-1:0]  ie_be_i,
  input  logic [NUM_CH-1:0] ie_wdata_i,
  input  logic [NUM_CH-1:0] err_i,
  output logic [NUM_CH-1:0] ie_o,
  output logic              irq_o
);
  logic [NUM_CH-1:0] err_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) err_q <= '0;
    else         err_q <= err_i;
  end

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ie
    localparam int unsigned LN = i / 8;
    if (LN < LANES) begin : g_wr
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)                    ie_o[i] <= 1'b0;
        else if (ie_we_i && ie_be_i[LN]) ie_o[i] <= ie_wdata_i[i];
      end
    end else begin : g_ro
      assign ie_o[i] = 1'b0;
    end
  end

  assign irq_o = |(err_q & ie_o);
endmodule

// File: rtl/dma_chan_en_regs.sv
module dma_chan_en_regs
  import dma_chan_en_pkg::*;
#(
  parameter int unsigned NUM_CH = 32,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned ADDR_W = 8
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [ADDR_W-1:0]   bus_addr_i,
  input  logic                bus_we_i,
  input  logic [DATA_W/8-1:0] bus_be_i,
  input  logic [DATA_W-1:0]   bus_wdata_i,
  output logic [DATA_W-1:0]   bus_rdata_o,
  input  logic [NUM_CH-1:0]   err_i,
  output logic [NUM_CH-1:0]   req_en_o,
  output logic                err_irq_o
);
  localparam int unsigned LANES = DATA_W / 8;

  logic              set_hit, ie_hit;
  logic [NUM_CH-1:0] lane_mask [LANES];
  logic [NUM_CH-1:0] set_vec;
  logic [NUM_CH-1:0] ie_q;

  assign set_hit = bus_we_i && (bus_addr_i == ADDR_W'(A_SETRQ));
  assign ie_hit  = bus_we_i && (bus_addr_i == ADDR_W'(A_ERRIE));

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    set_cmd_lane #(.NUM_CH(NUM_CH)) u_lane (
      .vld_i  (set_hit && bus_be_i[k]),
      .cmd_i  (bus_wdata_i[8*k +: 8]),
      .mask_o (lane_mask[k])
    );
  end

  always_comb begin
    set_vec = '0;
    for (int k = 0; k < LANES; k++) set_vec = set_vec | lane_mask[k];
  end

  req_en_reg #(.NUM_CH(NUM_CH)) u_req (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (set_vec),
    .en_o   (req_en_o)
  );

  err_irq_unit #(.NUM_CH(NUM_CH), .LANES(LANES)) u_err (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .ie_we_i    (ie_hit),
    .ie_be_i    (bus_be_i),
    .ie_wdata_i (bus_wdata_i[NUM_CH-1:0]),
    .err_i      (err_i),
    .ie_o       (ie_q),
    .irq_o      (err_irq_o)
  );

  // set-command address falls to default: write-only, reads zero
  always_comb begin
    bus_rdata_o = '0;
    unique case (bus_addr_i)
      ADDR_W'(A_REQEN): bus_rdata_o[NUM_CH-1:0] = req_en_o;
      ADDR_W'(A_ERRIE): bus_rdata_o[NUM_CH-1:0] = ie_q;
      default:          bus_rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/dma_chan_en_regs_chk.sv
module dma_chan_en_regs_chk #(
  parameter int unsigned NUM_CH = 32,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned ADDR_W = 8
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic [ADDR_W-1:0]   bus_addr_i,
  input logic                bus_we_i,
  input logic [DATA_W/8-1:0] bus_be_i,
  input logic [DATA_W-1:0]   bus_wdata_i,
  input logic [DATA_W-1:0]   bus_rdata_o,
  input logic [NUM_CH-1:0]   err_i,
  input logic [NUM_CH-1:0]   req_en_o,
  input logic                err_irq_o
);
  logic wr_set0;
  assign wr_set0 = bus_we_i && bus_addr_i == ADDR_W'(8'h14) && bus_be_i == 4'b0001;

  a_r2_never_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_en_o & $past(req_en_o)) == $past(req_en_o));

  a_r4_nop_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_set0 && bus_wdata_i[7]) |=> $stable(req_en_o));

  a_r3_global_all: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_set0 && bus_wdata_i[7:6] == 2'b01) |=> (req_en_o == '1));

  a_r1_single_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_set0 && bus_wdata_i[7:6] == 2'b00) |=>
      ($countones(req_en_o ^ $past(req_en_o)) <= 1));

  a_r5_cmd_reads_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_addr_i == ADDR_W'(8'h14)) |-> (bus_rdata_o == '0));

  a_r9_needs_error: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(err_i) == '0) |-> !err_irq_o);
endmodule

bind dma_chan_en_regs dma_chan_en_regs_chk #(
  .NUM_CH(NUM_CH), .DATA_W(DATA_W), .ADDR_W(ADDR_W)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .bus_addr_i  (bus_addr_i),
  .bus_we_i    (bus_we_i),
  .bus_be_i    (bus_be_i),
  .bus_wdata_i (bus_wdata_i),
  .bus_rdata_o (bus_rdata_o),
  .err_i       (err_i),
  .req_en_o    (req_en_o),
  .err_irq_o   (err_irq_o)
);

// File: tb/dma_chan_en_regs_bench.sv
module dma_chan_en_regs_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  addr = '0;
  logic        we = 1'b0;
  logic [3:0]  be = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [31:0] err = '0;
  logic [31:0] req_en;
  logic        irq;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  // behavioural reference state
  logic [31:0] m_req = '0;
  logic [31:0] m_ie = '0;
  logic [31:0] m_errq = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dma_chan_en_regs u_dma_chan_en_regs (
    .clk_i(clk), .rst_ni(rst_n), .bus_addr_i(addr), .bus_we_i(we),
    .bus_be_i(be), .bus_wdata_i(wdata), .bus_rdata_o(rdata),
    .err_i(err), .req_en_o(req_en), .err_irq_o(irq)
  );

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_req = '0; m_ie = '0; m_errq = '0;
    end else begin
      if (we && addr == 8'h14) begin
        for (int k = 0; k < 4; k++) begin
          logic [7:0] c;
          c = wdata[8*k +: 8];
          if (be[k] && !c[7]) begin
            if (c[6]) m_req = '1;
            else      m_req[c[4:0]] = 1'b1;
          end
        end
      end
      if (we && addr == 8'h18)
        for (int k = 0; k < 4; k++)
          if (be[k]) m_ie[8*k +: 8] = wdata[8*k +: 8];
      m_errq = err;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // every-cycle model comparison
  always @(negedge clk) if (rst_n && !done) begin
    chk("R2 req_en vs model", req_en, m_req);
    chk("R9 irq vs model", {31'd0, irq}, {31'd0, |(m_errq & m_ie)});
  end

  task automatic wr(input logic [7:0] a, input logic [3:0] b, input logic [31:0] d);
    @(negedge clk);
    addr = a; be = b; wdata = d; we = 1'b1;
    @(negedge clk);
    we = 1'b0; be = '0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    addr = a; #1;
    d = rdata;
  endtask

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    chk("R2 reset req_en", req_en, 32'h0);
    chk("R9 reset irq", {31'd0, irq}, 32'h0);
    rst_n = 1'b1;
    rd(8'h18, d); chk("R8 reset ie", d, 32'h0);

    wr(8'h14, 4'b0001, 32'h0000_0005);
    chk("R1 single ch5", req_en, 32'h0000_0020);
    rd(8'h0C, d); chk("R10 readback", d, 32'h0000_0020);
    rd(8'h14, d); chk("R5 cmd reads zero", d, 32'h0);

    wr(8'h14, 4'b0001, 32'h0000_0083);
    chk("R4 nop ignored", req_en, 32'h0000_0020);
    wr(8'h14, 4'b0001, 32'h0000_00C0);
    chk("R4 nop with global ignored", req_en, 32'h0000_0020);

    wr(8'h14, 4'b0001, 32'h0000_002A);
    chk("R6 bit5 ignored ch10", req_en, 32'h0000_0420);

    wr(8'h14, 4'b1011, 32'h1F03_0201);
    chk("R7 multi-lane", req_en, 32'h8000_0426);

    wr(8'h14, 4'b0001, 32'h0000_0005);
    chk("R2 repeat set keeps", req_en, 32'h8000_0426);

    wr(8'h0C, 4'b1111, 32'hFFFF_FFFF);
    chk("R10 write to readback ignored", req_en, 32'h8000_0426);
    rd(8'h00, d); chk("R10 unmapped zero", d, 32'h0);

    wr(8'h18, 4'b0011, 32'hFFFF_00F0);
    rd(8'h18, d); chk("R8 masked ie write", d, 32'h0000_00F0);

    @(negedge clk); err = 32'h0000_0004;
    @(negedge clk); chk("R9 disabled error", {31'd0, irq}, 32'h0);
    err = 32'h0000_0010;
    chk("R9 no same-cycle irq", {31'd0, irq}, 32'h0);
    @(negedge clk); chk("R9 irq after one clock", {31'd0, irq}, 32'h1);
    err = 32'h0;
    @(negedge clk); chk("R9 irq drops", {31'd0, irq}, 32'h0);

    wr(8'h14, 4'b0100, 32'h0045_0000);
    chk("R3 global set", req_en, 32'hFFFF_FFFF);
    rd(8'h14, d); chk("R5 cmd still reads zero", d, 32'h0);

    repeat (2) @(negedge clk);
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      total++; bad++;
      $display("FAIL watchdog act=hung exp=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule